// File: doc/BRIEF.md
# Interval Timer with Doubleword Timebase

This block is the system timer for a 36-bit processor. It keeps a 71-bit free-running timebase split into a 36-bit high word and a 35-bit low word. Software can load the timebase and read it back. A read always shows the 12 least significant bits of the high word as zero. A programmable interval period sets how many tick strobes pass between expiries. A time-to-go counter tracks the ticks that remain in the current interval.

On every expiry the block does four things. It adds the period into the timebase, carrying from the low word into the high word. It reloads time-to-go from the period. It sets an interrupt request flag, which stays set until it is cleared explicitly. An optional 36-bit quantum accumulator advances by a fixed amount on each expiry. It only advances when no processor interrupt is in progress and the slow (60 ticks per second) rate is selected.

Top module: `dword_interval_timer`

## Requirements
- R1: After synchronous reset the timebase, period, time-to-go, quantum and interrupt flag all read zero.
- R2: An interval write loads both the period and time-to-go with the written value, and the interval read port returns the period.
- R3: On expiry the period is added to the 35-bit low word, and the carry out of the low word (0, 1 or 2) is added into the high word.
- R4: The high word wraps modulo 2^36 when the carry overflows it.
- R5: The high-word read port returns the stored high word with bits 11..0 forced to zero. The low-word read port returns the 35-bit low word, zero-extended, so that bit 35 is zero.
- R6: A timebase write loads the high word unchanged and loads the low word with bit 35 of the written value dropped.
- R7: On a tick, when time-to-go is 0 or 1, an expiry occurs and time-to-go is reloaded with the period.
- R8: The interrupt flag is set by an expiry and held until a clear command. When a clear and an expiry fall in the same cycle, the flag ends up set.
- R9: A timebase write in the same cycle as an expiry takes priority, and that expiry's increment is lost.
- R10: With the rate select at 0 (60 ticks per second) and no processor interrupt active, each expiry adds 68333 (4.1 MHz divided by 60) to the quantum.
- R11: The quantum holds its value when the processor-interrupt-active input is high or the rate select is 1 (1001 ticks per second).
- R12: A tick that arrives while time-to-go is greater than 1 decrements time-to-go by one. It leaves the timebase, the interrupt flag and the quantum untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| tick_i | input | 1 | Single-cycle tick strobe at the nominal rate |
| rate_sel_i | input | 1 | 0 = 60 ticks/s, 1 = 1001 ticks/s |
| pi_active_i | input | 1 | A processor priority interrupt is in progress |
| tb_wr_i | input | 1 | Load the timebase |
| tb_wr_hi_i | input | 36 | High word to load |
| tb_wr_lo_i | input | 36 | Low word to load (bit 35 ignored) |
| tb_rd_hi_o | output | 36 | High word, low 12 bits masked |
| tb_rd_lo_o | output | 36 | Low word, bit 35 zero |
| iv_wr_i | input | 1 | Load the interval period |
| iv_wdata_i | input | 36 | Period value to load |
| iv_rdata_o | output | 36 | Current period |
| ttg_o | output | 36 | Current time-to-go |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| irq_o | output | 1 | Timer interrupt request flag |
| quantum_o | output | 36 | Quantum accumulator |

## Verification
The assertions assume that tick, clear and write commands are single-cycle strobes, sampled only on rising clock edges while reset is low. They also assume that every input is at a known level at each edge. The stimulus drives all inputs at the falling edge and returns every strobe to zero just after the following rising edge. Each command therefore lasts exactly one cycle. Coincident commands, such as a clear or a timebase write together with an expiry, are raised together inside that same single cycle, so the priority rules are exercised without stretching any strobe.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int WORD_W = 36;
  localparam int LO_W   = 35;
  localparam int TB_W   = WORD_W + LO_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LO_W-1:0]   low_t;

  // add an increment into the split timebase; returns {high, low}
  function automatic logic [TB_W-1:0] tb_add(word_t hi, low_t lo, word_t inc);
    logic [LO_W+1:0] s;
    s = {2'b00, lo} + {1'b0, inc};
    return {hi + WORD_W'(s[LO_W+1:LO_W]), s[LO_W-1:0]};
  endfunction

  // force the n lowest bits of a word to zero
  function automatic word_t lsb_clear(word_t w, int unsigned n);
    return w & ~((word_t'(1) << n) - word_t'(1));
  endfunction
endpackage

// File: rtl/ivt_interval.sv
module ivt_interval
  import ivt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  iv_wr,
  input  word_t iv_wdata,
  input  logic  irq_clr,
  output word_t period,
  output word_t ttg,
  output logic  irq,
  output logic  expire
);
  word_t period_q, ttg_q;
  logic  irq_q;

  assign expire = tick && (ttg_q <= word_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      ttg_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (iv_wr) period_q <= iv_wdata;
      if (iv_wr)       ttg_q <= iv_wdata;
      else if (expire) ttg_q <= period_q;
      else if (tick)   ttg_q <= ttg_q - word_t'(1);
      if (expire)       irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign period = period_q;
  assign ttg    = ttg_q;
  assign irq    = irq_q;

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq_q);
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_clr) |=> irq_q);
  assert_ttg_load_R2: assert property (@(posedge clk) disable iff (rst)
    iv_wr |=> (ttg_q == period_q));
  assert_ttg_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (!tick && !iv_wr) |=> $stable(ttg_q));
endmodule

// File: rtl/ivt_timebase.sv
module ivt_timebase
  import ivt_pkg::*;
#(
  parameter int MASK_BITS = 12
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  expire,
  input  word_t incr,
  input  logic  wr_en,
  input  word_t wr_hi,
  input  word_t wr_lo,
  output word_t rd_hi,
  output word_t rd_lo
);
  word_t hi_q;
  low_t  lo_q;
  logic [TB_W-1:0] sum;

  assign sum = tb_add(hi_q, lo_q, incr);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      hi_q <= wr_hi;
      lo_q <= wr_lo[LO_W-1:0];
    end else if (expire) begin
      {hi_q, lo_q} <= sum;
    end
  end

  assign rd_hi = lsb_clear(hi_q, MASK_BITS);
  assign rd_lo = {1'b0, lo_q};

  assert_wr_load_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (hi_q == $past(wr_hi)));
  assert_tb_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !expire) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/ivt_quantum.sv
module ivt_quantum
  import ivt_pkg::*;
#(
  parameter word_t STEP = word_t'(68333)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  expire,
  input  logic  pi_active,
  input  logic  rate_sel,
  output word_t quantum
);
  word_t q_q;
  logic  advance;

  assign advance = expire && !pi_active && !rate_sel;

  always_ff @(posedge clk) begin
    if (rst)          q_q <= '0;
    else if (advance) q_q <= q_q + STEP;
  end

  assign quantum = q_q;

  assert_q_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (pi_active || rate_sel) |=> $stable(q_q));
endmodule

// File: rtl/dword_interval_timer.sv
module dword_interval_timer
  import ivt_pkg::*;
#(
  parameter int MASK_BITS = 12,
  parameter int HW_FREQ   = 4100000,
  parameter int SLOW_TPS  = 60,
  parameter bit QUANT_EN  = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        rate_sel_i,
  input  logic        pi_active_i,
  input  logic        tb_wr_i,
  input  logic [35:0] tb_wr_hi_i,
  input  logic [35:0] tb_wr_lo_i,
  output logic [35:0] tb_rd_hi_o,
  output logic [35:0] tb_rd_lo_o,
  input  logic        iv_wr_i,
  input  logic [35:0] iv_wdata_i,
  output logic [35:0] iv_rdata_o,
  output logic [35:0] ttg_o,
  input  logic        irq_clr_i,
  output logic        irq_o,
  output logic [35:0] quantum_o
);
  localparam word_t QSTEP = word_t'(HW_FREQ / SLOW_TPS);

  logic  expire_evt;
  word_t period_w;

  ivt_interval u_interval (
    .clk(clk), .rst(rst), .tick(tick_i), .iv_wr(iv_wr_i), .iv_wdata(iv_wdata_i),
    .irq_clr(irq_clr_i), .period(period_w), .ttg(ttg_o), .irq(irq_o),
    .expire(expire_evt)
  );

  ivt_timebase #(.MASK_BITS(MASK_BITS)) u_timebase (
    .clk(clk), .rst(rst), .expire(expire_evt), .incr(period_w),
    .wr_en(tb_wr_i), .wr_hi(tb_wr_hi_i), .wr_lo(tb_wr_lo_i),
    .rd_hi(tb_rd_hi_o), .rd_lo(tb_rd_lo_o)
  );

  assign iv_rdata_o = period_w;

  generate
    if (QUANT_EN) begin : g_quant
      ivt_quantum #(.STEP(QSTEP)) u_quantum (
        .clk(clk), .rst(rst), .expire(expire_evt), .pi_active(pi_active_i),
        .rate_sel(rate_sel_i), .quantum(quantum_o)
      );
    end else begin : g_noquant
      assign quantum_o = '0;
    end
  endgenerate

  assert_rd_lo_clear_R5: assert property (@(posedge clk) disable iff (rst)
    tb_wr_i |=> (tb_rd_lo_o[35] == 1'b0));
endmodule

// File: tb/test_dword_interval_timer.sv
module test_dword_interval_timer;
  typedef struct {
    string       tag;
    logic [35:0] hi, lo, per, ttg, q;
    logic        irq;
  } exp_t;

  logic clk = 0, rst = 1;
  logic tick = 0, rsel = 0, pi = 0, tbw = 0, ivw = 0, clr = 0;
  logic [35:0] whi = 0, wlo = 0, ivd = 0;
  logic [35:0] rhi, rlo, per, ttg, qo;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t sb[$];

  logic [70:0] m_tb = 0;
  logic [35:0] m_per = 0, m_ttg = 0, m_q = 0;
  logic m_irq = 0;

  always #5 clk = ~clk;

  dword_interval_timer i_dword_interval_timer (
    .clk(clk), .rst(rst), .tick_i(tick), .rate_sel_i(rsel), .pi_active_i(pi),
    .tb_wr_i(tbw), .tb_wr_hi_i(whi), .tb_wr_lo_i(wlo), .tb_rd_hi_o(rhi),
    .tb_rd_lo_o(rlo), .iv_wr_i(ivw), .iv_wdata_i(ivd), .iv_rdata_o(per),
    .ttg_o(ttg), .irq_clr_i(clr), .irq_o(irq), .quantum_o(qo)
  );

  task automatic chk(string tag, string what, logic [35:0] act, logic [35:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "tb_hi", rhi, e.hi);
      chk(e.tag, "tb_lo", rlo, e.lo);
      chk(e.tag, "period", per, e.per);
      chk(e.tag, "ttg", ttg, e.ttg);
      chk(e.tag, "quantum", qo, e.q);
      chk(e.tag, "irq", {35'b0, irq}, {35'b0, e.irq});
    end
  end

  task automatic push(string tag);
    exp_t e;
    e.tag = tag;
    e.hi  = m_tb[70:35] & 36'hFFFFFF000;
    e.lo  = {1'b0, m_tb[34:0]};
    e.per = m_per; e.ttg = m_ttg; e.q = m_q; e.irq = m_irq;
    sb.push_back(e);
  endtask

  // driver: one cycle of stimulus, reference update, expected item
  task automatic step(string tag, bit t, bit c, bit p, bit rs,
                      bit w, logic [35:0] h, logic [35:0] l,
                      bit iw, logic [35:0] d);
    bit ex;
    @(negedge clk);
    tick = t; clr = c; pi = p; rsel = rs; tbw = w; whi = h; wlo = l; ivw = iw; ivd = d;
    @(posedge clk);
    #1;
    tick = 0; clr = 0; tbw = 0; ivw = 0;
    ex = t && (m_ttg < 36'd2);
    if (w) m_tb = {h, l[34:0]};
    else if (ex) m_tb = m_tb + {35'b0, m_per};
    if (ex) m_irq = 1; else if (c) m_irq = 0;
    if (ex && !p && !rs) m_q = m_q + 36'd68333;
    if (iw) m_ttg = d; else if (ex) m_ttg = m_per; else if (t) m_ttg = m_ttg - 1;
    if (iw) m_per = d;
    push(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    push("R1_reset");
    step("R2_ivwrite", 0,0,0,0, 0,0,0, 1,36'd2);
    step("R12_tick_dec", 1,0,0,0, 0,0,0, 0,0);
    step("R3_R7_R8_R10_expire", 1,0,0,0, 0,0,0, 0,0);
    step("R8_hold", 0,0,0,0, 0,0,0, 0,0);
    step("R8_clear", 0,1,0,0, 0,0,0, 0,0);
    step("R5_R6_tbwrite", 0,0,0,0, 1,36'h123456FFF,36'hFFFFFFFF0, 0,0);
    step("R2_period20", 0,0,0,0, 0,0,0, 1,36'h20);
    step("R3_carry1", 1,0,0,0, 0,0,0, 0,0);
    step("R2_periodmax", 0,0,0,0, 0,0,0, 1,36'hFFFFFFFFF);
    step("R6_tbwrite2", 0,0,0,0, 1,36'h123456FFE,36'h7FFFFFFFF, 1,36'hFFFFFFFFF);
    step("R3_carry2", 1,0,0,0, 0,0,0, 0,0);
    step("R2_period1", 0,0,0,0, 1,36'hFFFFFFFFF,36'h7FFFFFFFF, 1,36'd1);
    step("R4_wrap", 1,0,0,0, 0,0,0, 0,0);
    step("R8_clr_vs_set", 1,1,0,0, 0,0,0, 0,0);
    step("R9_write_wins", 1,0,0,0, 1,36'hABCDE0000,36'h55, 0,0);
    step("R11_pi_active", 1,0,1,0, 0,0,0, 0,0);
    step("R11_fast_rate", 1,0,0,1, 0,0,0, 0,0);
    step("R10_advance", 1,0,0,0, 0,0,0, 0,0);
    step("R2_period3", 0,0,0,0, 0,0,0, 1,36'd3);
    step("R12_no_side_effect", 1,1,0,0, 0,0,0, 0,0);
    step("R12_dec_again", 1,0,0,0, 0,0,0, 0,0);
    step("R7_reload", 1,0,0,0, 0,0,0, 0,0);
    wait (sb.size() == 0);
    @(negedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule